// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block holds a programmed SDRAM mode word, decodes it, and, for every read or write burst the controller launches, produces the column address of each beat in order. The controller supplies a start strobe with the first column and a read/write flag. The block then presents one column address per clock with a valid flag and pulses a done flag once the burst has run out. A terminate input cuts any burst short, and a fresh start strobe may replace a running burst at once.

Column ordering follows the programmed burst length and burst type. For lengths 2, 4 and 8 the address stays inside an aligned block and only its low bits move: they count upward with wrap-around in sequential mode, or take the start value XORed with the beat number in interleaved mode. A full-page burst walks the whole row with wrap from the last column to column 0 and runs until terminated. A single-location write option turns every write into one beat while reads keep the programmed length. The decoded read latency and an illegal-mode flag are also brought out.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the mode word is 13'h0020: burst length 1, sequential, latency 2, standard operation, so `cas_lat` reads 2, `mode_bad` reads 0 and `col_valid` reads 0. `cas_lat` shows 2 for latency field (bits 6:4) 010, 3 for 011, and 0 for any other code.
- R2: `mode_bad` is 1 exactly when the held mode has a length field (bits 2:0) other than 000, 001, 010, 011 or 111, a latency field other than 010 or 011, an operating field (bits 8:7) other than 00, or the full-page code 111 together with interleaved type (bit 3 = 1). Bits 12:10 are ignored.
- R3: While `mode_bad` is 1, a start strobe is ignored and `col_valid` stays 0.
- R4: A start accepted at a clock edge shows the starting column with `col_valid` = 1 from the next cycle on, and one new beat appears every cycle after that.
- R5: For length codes 001, 010 and 011 (2, 4, 8 beats) the column bits above the low log2(N) bits keep the start value for the whole burst.
- R6: In sequential mode (bit 3 = 0) the low bits count up by one each beat and wrap to zero within the block (length 8, start 5: 5,6,7,0,1,2,3,4).
- R7: In interleaved mode (bit 3 = 1) the low bits of beat i equal the start low bits XOR i (length 8, start 5: 5,4,7,6,1,0,3,2).
- R8: With length code 111 the column increments by one each beat from any start, wraps from the last column to 0, and continues until `stop`.
- R9: With length code 000 a burst is one beat at exactly the start column, whatever bit 3 holds.
- R10: With bit 9 = 1, a write burst is one beat at the start column, while a read burst uses the programmed length.
- R11: `burst_done` is high for one cycle, the cycle right after the final beat of a burst that ran out or was terminated, with `col_valid` low in that cycle; a burst cut short by a new start gives no done pulse.
- R12: `stop` high at an edge where a beat is shown makes that beat the last one; the next cycle has `col_valid` = 0 and `burst_done` = 1.
- R13: A start strobe during a running burst ends it and shows the new burst's first column in the next cycle; start takes priority over `stop` in the same cycle.
- R14: A mode write is taken only at an edge where no beat is shown and no start strobe is present; otherwise the held mode is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_word | input | 13 | New mode word |
| start | input | 1 | Burst launch strobe |
| start_col | input | COL_W | Starting column of the burst |
| is_write | input | 1 | 1 for a write burst, 0 for a read |
| stop | input | 1 | Terminate the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is shown this cycle |
| burst_done | output | 1 | One-cycle pulse after a burst ends |
| cas_lat | output | 2 | Decoded read latency (2, 3 or 0 if reserved) |
| mode_bad | output | 1 | Held mode word is illegal |

## Verification
The bench targets the wrap point of sequential bursts started mid-block, where an ordering that spilled a carry would alter the block bits, and the XOR pattern of interleaved bursts, which a design that added instead would turn into a sequential order. Full-page bursts are launched near the end of the row so that a missing wrap would run past the last column, and length-one bursts are run with the type bit set to catch a design that let it reorder anything. Single-location writes, terminate on the first and middle beats, a start replacing a burst, and mode writes attempted while busy or together with a start are also driven; a design with wrong priorities there would emit extra beats, a missing or stray done pulse, or a changed latency readout.

// File: rtl/sbs_pkg.sv
// Shared types for the burst column sequencer.
// Assumes the mode word fields sit at fixed positions decoded by neighbours.
package sbs_pkg;

    // Length field codes
    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } len_code_e;

    // Low ten bits of the mode word; packed MSB first matches bit positions 9:0
    typedef struct packed {
        logic       wr_single;  // bit 9
        logic [1:0] op_field;   // bits 8:7
        logic [2:0] lat_field;  // bits 6:4
        logic       order_ilv;  // bit 3
        logic [2:0] len_field;  // bits 2:0
    } mode_t;

    localparam logic [9:0] MODE_RESET = 10'h020;

endpackage

// File: rtl/sbs_mode_reg.sv
// Mode holding register and decoder.
// Holds the low ten bits of the mode word, decodes latency and legality.
// Assumes the caller only raises `accept` when no burst is running.
module sbs_mode_reg
    import sbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        accept,
    input  logic [9:0]  word_in,
    output mode_t       mode_q,
    output logic        bad,
    output logic [1:0]  lat
);

    logic len_ok;
    logic lat_ok;

    // Capture a new mode word when permitted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_t'(MODE_RESET);
        end else if (wr_en && accept) begin
            mode_q <= mode_t'(word_in);
        end
    end

    // Classify the length field
    always_comb begin
        case (mode_q.len_field)
            LEN_1, LEN_2, LEN_4, LEN_8, LEN_PAGE: len_ok = 1'b1;
            default:                              len_ok = 1'b0;
        endcase
    end

    // Decode read latency; reserved codes read as zero
    always_comb begin
        lat_ok = 1'b1;
        case (mode_q.lat_field)
            3'b010:  lat = 2'd2;
            3'b011:  lat = 2'd3;
            default: begin
                lat    = 2'd0;
                lat_ok = 1'b0;
            end
        endcase
    end

    // Combine all legality conditions
    always_comb begin
        bad = !len_ok || !lat_ok || (mode_q.op_field != 2'b00)
              || ((mode_q.len_field == LEN_PAGE) && mode_q.order_ilv);
    end

endmodule

// File: rtl/sbs_beat_ctrl.sv
// Beat controller: tracks whether a burst runs, its start column,
// the beat index and the burst shape latched at launch.
// Assumes `launch` is already qualified by mode legality.
module sbs_beat_ctrl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [COL_W-1:0] col_in,
    input  logic [COL_W-1:0] mask_in,
    input  logic             page_in,
    input  logic             ilv_in,
    input  logic             stop,
    output logic             active,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] idx_q,
    output logic [COL_W-1:0] mask_q,
    output logic             page_q,
    output logic             ilv_q,
    output logic             done_q
);

    logic last_beat;

    // Final beat of a bounded burst: index reached length minus one
    always_comb begin
        last_beat = !page_q && (idx_q == mask_q);
    end

    // Burst state: launch wins, then stop or natural end, else advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
            ilv_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (launch) begin
            active <= 1'b1;
            base_q <= col_in;
            idx_q  <= '0;
            mask_q <= mask_in;
            page_q <= page_in;
            ilv_q  <= ilv_in;
            done_q <= 1'b0;
        end else if (active && (stop || last_beat)) begin
            active <= 1'b0;
            done_q <= 1'b1;
        end else if (active) begin
            idx_q  <= idx_q + 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sbs_addr_gen.sv
// Column address generator: keeps bits outside the mask from the start
// column and reorders bits inside it, by addition or by XOR with the index.
// Assumes the mask is a contiguous run of low ones.
module sbs_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;

    // Sequential candidate; carries out of the mask are discarded per bit
    always_comb begin
        sum = base + idx;
    end

    // Per-bit selection between start bit and reordered bit
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask[b])
                col[b] = base[b];
            else if (ilv)
                col[b] = base[b] ^ idx[b];
            else
                col[b] = sum[b];
        end
    end

endmodule

// File: rtl/sdram_burst_seq.sv
// Top of the burst column sequencer.
// Links the mode register, shape selection, beat control and address
// generation. Assumes COL_W >= 3 so that an 8-beat block fits in a row.
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [12:0]      mode_word,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             is_write,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             burst_done,
    output logic [1:0]       cas_lat,
    output logic             mode_bad
);

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    mode_t            mode_bits;
    logic             launch;
    logic             mode_accept;
    logic             one_beat;
    logic [COL_W-1:0] mask_sel;
    logic             page_sel;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    logic             page_q;
    logic             ilv_q;
    logic             unused_hi;

    assign unused_hi = ^mode_word[12:10];

    // Qualify launch and mode writes
    always_comb begin
        launch      = start && !mode_bad;
        mode_accept = !col_valid && !start;
    end

    sbs_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .accept  (mode_accept),
        .word_in (mode_word[9:0]),
        .mode_q  (mode_bits),
        .bad     (mode_bad),
        .lat     (cas_lat)
    );

    // Pick the burst shape for the launch in this cycle
    always_comb begin
        one_beat = mode_bits.wr_single && is_write;
        page_sel = 1'b0;
        case (mode_bits.len_field)
            LEN_2:    mask_sel = COL_W'(1);
            LEN_4:    mask_sel = COL_W'(3);
            LEN_8:    mask_sel = COL_W'(7);
            LEN_PAGE: begin
                mask_sel = ALL_ONES;
                page_sel = 1'b1;
            end
            default:  mask_sel = '0;
        endcase
        if (one_beat) begin
            mask_sel = '0;
            page_sel = 1'b0;
        end
    end

    sbs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .col_in  (start_col),
        .mask_in (mask_sel),
        .page_in (page_sel),
        .ilv_in  (mode_bits.order_ilv),
        .stop    (stop),
        .active  (col_valid),
        .base_q  (base_q),
        .idx_q   (idx_q),
        .mask_q  (mask_q),
        .page_q  (page_q),
        .ilv_q   (ilv_q),
        .done_q  (burst_done)
    );

    sbs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base (base_q),
        .idx  (idx_q),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (col_out)
    );

endmodule

// File: rtl/sbs_checks.sv
// Property checker for the burst column sequencer, bound to the top.
module sbs_checks #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             burst_done,
    input logic             mode_bad,
    input logic [COL_W-1:0] mask_q,
    input logic             ilv_q,
    input logic [9:0]       mode_bits
);

    AST_NO_BEAT_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> !mode_bad); // R3

    AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && !$past(start))
        |-> ((col_out & ~mask_q) == ($past(col_out) & ~mask_q))); // R5

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid) && !$past(start) && !ilv_q)
        |-> (((col_out - $past(col_out)) & mask_q) == COL_W'(1))); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> ($past(col_valid) && !col_valid)); // R11

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop) && $past(col_valid) && !$past(start))
        |-> (!col_valid && burst_done)); // R12

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(col_valid) |-> $stable(mode_bits)); // R14

endmodule

bind sdram_burst_seq sbs_checks #(.COL_W(COL_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .col_out    (col_out),
    .col_valid  (col_valid),
    .burst_done (burst_done),
    .mode_bad   (mode_bad),
    .mask_q     (mask_q),
    .ilv_q      (ilv_q),
    .mode_bits  (mode_bits)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
    localparam int COL_W = 10;
    localparam int COLS  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_we = 1'b0;
    logic [12:0]      mode_word = '0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             is_write = 1'b0;
    logic             stop = 1'b0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             burst_done;
    logic [1:0]       cas_lat;
    logic             mode_bad;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    sdram_burst_seq #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_word(mode_word),
        .start(start), .start_col(start_col), .is_write(is_write), .stop(stop),
        .col_out(col_out), .col_valid(col_valid), .burst_done(burst_done),
        .cas_lat(cas_lat), .mode_bad(mode_bad)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    logic [9:0] m_mode;
    logic [9:0] m_old;
    bit         m_old_bad;
    bit         m_act = 0;
    bit         m_done = 0;
    bit         m_page = 0;
    bit         ready = 0;
    int         m_cur;
    int         q[$];
    int         n_len;
    int         blk;
    int         s_low;

    function automatic bit m_bad(input logic [9:0] m);
        bit len_ok;
        len_ok = (m[2:0] == 3'd0) || (m[2:0] == 3'd1) || (m[2:0] == 3'd2)
                 || (m[2:0] == 3'd3) || (m[2:0] == 3'd7);
        return !len_ok || !((m[6:4] == 3'd2) || (m[6:4] == 3'd3))
               || (m[8:7] != 2'b00) || ((m[2:0] == 3'd7) && m[3]);
    endfunction

    function automatic int m_lat(input logic [9:0] m);
        if (m[6:4] == 3'd2) return 2;
        if (m[6:4] == 3'd3) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_mode = 10'h020;
            m_act = 0;
            m_done = 0;
            q.delete();
            ready = 1;
        end else begin
            m_old = m_mode;
            m_old_bad = m_bad(m_mode);
            if (mode_we && !m_act && !start) m_mode = mode_word[9:0];
            m_done = 0;
            if (start && !m_old_bad) begin
                q.delete();
                m_act = 1;
                m_page = 0;
                if (m_old[9] && is_write) begin
                    q.push_back(int'(start_col));
                end else if (m_old[2:0] == 3'd7) begin
                    m_page = 1;
                    m_cur = int'(start_col);
                end else begin
                    n_len = 1 << m_old[2:0];
                    blk = (int'(start_col) / n_len) * n_len;
                    s_low = int'(start_col) % n_len;
                    for (int i = 0; i < n_len; i++)
                        q.push_back(blk + (m_old[3] ? (s_low ^ i) : ((s_low + i) % n_len)));
                end
            end else if (m_act) begin
                if (stop) begin
                    m_act = 0;
                    m_done = 1;
                end else if (m_page) begin
                    m_cur = (m_cur + 1) % COLS;
                end else begin
                    void'(q.pop_front());
                    if (q.size() == 0) begin
                        m_act = 0;
                        m_done = 1;
                    end
                end
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (ready && rst_n) begin
            check({cur_req, " valid"}, int'(col_valid), int'(m_act));
            check({cur_req, " done"}, int'(burst_done), int'(m_done));
            check({cur_req, " R2 bad"}, int'(mode_bad), int'(m_bad(m_mode)));
            check({cur_req, " R1 lat"}, int'(cas_lat), m_lat(m_mode));
            if (m_act)
                check({cur_req, " col"}, int'(col_out), m_page ? m_cur : q[0]);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (R4 progress): actual hung expected finish");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [12:0] mw(input logic [2:0] len, input logic ilv,
                                       input logic [2:0] lat, input logic [1:0] op,
                                       input logic ws);
        return {3'b000, ws, op, lat, ilv, len};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [12:0] m);
        mode_we = 1'b1;
        mode_word = m;
        tick(1);
        mode_we = 1'b0;
    endtask

    task automatic launch(input int col, input logic wr);
        start = 1'b1;
        start_col = COL_W'(col);
        is_write = wr;
        tick(1);
        start = 1'b0;
    endtask

    int exp_seq[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
    int exp_ilv[8] = '{5, 4, 7, 6, 1, 0, 3, 2};

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        cur_req = "R1";
        check("R1 reset lat", int'(cas_lat), 2);
        check("R1 reset bad", int'(mode_bad), 0);
        check("R1 reset valid", int'(col_valid), 0);

        // R6: length 8 sequential, start 5 inside block 0x2A8
        cur_req = "R6";
        set_mode(mw(3'd3, 1'b0, 3'd3, 2'b00, 1'b0));
        check("R1 lat 3", int'(cas_lat), 3);
        launch(32'h2AD, 1'b0);
        for (int i = 0; i < 8; i++) begin
            check("R6 seq order", int'(col_out), 32'h2A8 + exp_seq[i]);
            check("R5 block held", int'(col_out) & ~7, 32'h2A8);
            tick(1);
        end
        check("R11 done after last", int'(burst_done), 1);
        tick(2);

        // R7: length 8 interleaved
        cur_req = "R7";
        set_mode(mw(3'd3, 1'b1, 3'd2, 2'b00, 1'b0));
        launch(32'h135, 1'b1);
        for (int i = 0; i < 8; i++) begin
            check("R7 xor order", int'(col_out), 32'h130 + exp_ilv[i]);
            tick(1);
        end
        tick(2);

        // R5/R6: length 4 sequential and length 2 interleaved
        cur_req = "R5";
        set_mode(mw(3'd2, 1'b0, 3'd2, 2'b00, 1'b0));
        launch(32'h3FE, 1'b0);
        tick(6);
        set_mode(mw(3'd1, 1'b1, 3'd2, 2'b00, 1'b0));
        launch(32'h0F1, 1'b0);
        tick(4);

        // R9: length 1 with the type bit set
        cur_req = "R9";
        set_mode(mw(3'd0, 1'b1, 3'd2, 2'b00, 1'b0));
        launch(32'h17F, 1'b0);
        check("R9 single col", int'(col_out), 32'h17F);
        tick(1);
        check("R9 ends", int'(col_valid), 0);
        tick(2);

        // R8/R12: full page near row end, then stop
        cur_req = "R8";
        set_mode(mw(3'd7, 1'b0, 3'd3, 2'b00, 1'b0));
        launch(1020, 1'b0);
        tick(6);
        check("R8 wrapped", int'(col_out), 2);
        stop = 1'b1;
        tick(1);
        stop = 1'b0;
        check("R12 stop ends", int'(col_valid), 0);
        tick(2);

        // R10: single-location writes, reads keep length 4
        cur_req = "R10";
        set_mode(mw(3'd2, 1'b0, 3'd2, 2'b00, 1'b1));
        launch(32'h046, 1'b1);
        tick(1);
        check("R10 write one beat", int'(col_valid), 0);
        tick(1);
        launch(32'h046, 1'b0);
        tick(5);
        set_mode(mw(3'd7, 1'b0, 3'd2, 2'b00, 1'b1));
        launch(32'h200, 1'b1);
        tick(3);

        // R12: stop on first and middle beat of length 8
        cur_req = "R12";
        set_mode(mw(3'd3, 1'b0, 3'd2, 2'b00, 1'b0));
        start = 1'b1; start_col = 10'h011; is_write = 1'b0; stop = 1'b1;
        tick(1);
        start = 1'b0;
        tick(1);
        stop = 1'b0;
        tick(2);
        launch(32'h022, 1'b0);
        tick(3);
        stop = 1'b1;
        tick(1);
        stop = 1'b0;
        tick(2);

        // R13: restart mid-burst, also together with stop
        cur_req = "R13";
        launch(32'h0A3, 1'b0);
        tick(2);
        launch(32'h1C6, 1'b0);
        check("R13 new first col", int'(col_out), 32'h1C6);
        check("R13 no done on cut", int'(burst_done), 0);
        tick(2);
        stop = 1'b1;
        launch(32'h300, 1'b0);
        stop = 1'b0;
        tick(9);

        // R14: mode writes during a burst or with a start are dropped
        cur_req = "R14";
        launch(32'h010, 1'b0);
        set_mode(mw(3'd3, 1'b0, 3'd1, 2'b00, 1'b0));
        tick(8);
        check("R14 ignored busy", int'(mode_bad), 0);
        mode_we = 1'b1;
        mode_word = mw(3'd3, 1'b0, 3'd5, 2'b00, 1'b0);
        launch(32'h050, 1'b0);
        mode_we = 1'b0;
        tick(9);
        check("R14 ignored start", int'(cas_lat), 2);

        // R2/R3: illegal modes block bursts
        cur_req = "R3";
        set_mode(mw(3'd4, 1'b0, 3'd2, 2'b00, 1'b0));
        check("R2 reserved length", int'(mode_bad), 1);
        launch(32'h001, 1'b0);
        check("R3 no beat", int'(col_valid), 0);
        set_mode(mw(3'd2, 1'b0, 3'd1, 2'b00, 1'b0));
        check("R2 reserved latency", int'(mode_bad), 1);
        set_mode(mw(3'd2, 1'b0, 3'd2, 2'b01, 1'b0));
        check("R2 op field", int'(mode_bad), 1);
        set_mode(mw(3'd7, 1'b1, 3'd2, 2'b00, 1'b0));
        check("R2 page interleaved", int'(mode_bad), 1);
        launch(32'h002, 1'b0);
        tick(2);
        set_mode(13'h1C00 | mw(3'd2, 1'b0, 3'd3, 2'b00, 1'b0));
        check("R2 high bits ignored", int'(mode_bad), 0);
        cur_req = "R4";
        launch(32'h0C1, 1'b0);
        check("R4 first beat", int'(col_out), 32'h0C1);
        tick(6);

        finish_run();
    end
endmodule